// File: doc/BRIEF.md
# Multiplexed GPIO Port With Edge Interrupts

This block controls a port of general-purpose pins. Software reaches it through a small register bus with a combinational read and a single-cycle write. Per-bit registers hold the output value, the direction, the resistor enable, the function select, the interrupt enable, the edge polarity and the interrupt flags.

For every pin the block works out four things: whether the pad driver is on, what value the pad drives (or which way the resistor pulls), the input value seen by software and by the peripherals, and whether that pin requests an interrupt. A pin's function select hands its driver to a peripheral. A per-pin analog-disable input, supplied by an external comparator control, overrides everything else. Pad inputs pass through a two-flop synchronizer. Edges on pins in plain I/O mode set sticky flags, and these flags are combined into one port interrupt.

Top module: `gpio_port_mux`

Register selects on `bus_addr`: 0 input level (read-only), 1 output value, 2 direction, 3 resistor enable, 4 function select, 5 interrupt enable, 6 edge select, 7 interrupt flags. Bit i of each register belongs to pin i.

## Requirements
- R1: After reset, every register reads 0, every `pad_oe` and `pad_pull_en` bit is 0, and `port_irq` is 0.
- R2: With function select 0, `pad_oe` follows the direction bit (1 = output, 0 = input), and `pad_dout` follows the output register.
- R3: With function select 1, the pin's driver enable comes from `periph_oe` and its driven value from `periph_out`. If the peripheral does not drive the pin, `pad_dout` carries the output register bit.
- R4: A pin that has its resistor enabled and that is not driven gets `pad_pull_en` = 1. In that state `pad_dout` equals the output register bit, where 1 means pull-up and 0 means pull-down. A driven pin never has its pull enabled.
- R5: The input register and `periph_in` return the pad level after two clock edges of synchronization. Writes to the input register have no effect.
- R6: With edge select 0, a rising input edge sets the pin's flag. With edge select 1, a falling edge sets it. An edge of the other polarity leaves the flag unchanged. A flag stays set until software changes it.
- R7: `pin_irq[i]` is 1 exactly when flag i and enable i are both 1. `port_irq` is the OR of all `pin_irq` bits.
- R8: When `analog_dis[i]` is 1, the pin's driver and pull are off, its input register bit and `periph_in` bit read 0, and its edges set no flag. Clearing `analog_dis` afterwards does not create a flag.
- R9: A pin with function select 1 sets no flag on input edges.
- R10: A software write to the flag register loads the written value. A written 1 sets the flag and can raise the interrupt.
- R11: If a hardware edge arrives in the same cycle as a software write of 0 to that flag, the flag ends up set.
- R12: Changing an edge-select bit does not set a flag by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register select |
| bus_we | input | 1 | Write strobe for the selected register |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data of the selected register (combinational) |
| pad_in | input | NPINS | Raw pad levels |
| pad_oe | output | NPINS | Pad driver enable |
| pad_dout | output | NPINS | Drive value, or pull direction when the resistor is on |
| pad_pull_en | output | NPINS | Resistor enable to the pad |
| periph_out | input | NPINS | Peripheral output data |
| periph_oe | input | NPINS | Peripheral direction (1 = drive) |
| periph_in | output | NPINS | Synchronized, masked input value to the peripherals |
| analog_dis | input | NPINS | Analog-disable override from the comparator control |
| pin_irq | output | NPINS | Per-pin interrupt requests |
| port_irq | output | 1 | Combined port interrupt |

## Verification
The bench aims a hardware edge at the exact cycle of a software flag clear. A design that lets the write win would drop that interrupt. It toggles the edge-select bit while the pin is high, and releases analog-disable while the pin is high. A design that edge-detects the gated level or the polarity-adjusted level would then post a false flag. It also sends edges on a peripheral-owned pin, because a design that ignores the function select there would flag them. Finally, it reads the input register one edge too early and again on time, which catches a synchronizer with the wrong depth. It also writes to that read-only register, which would expose a writable one.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
   localparam int REG_AW = 3;

   typedef enum logic [REG_AW-1:0] {
      SEL_LEVEL  = 3'd0,
      SEL_DRIVE  = 3'd1,
      SEL_DIR    = 3'd2,
      SEL_RES    = 3'd3,
      SEL_FUNC   = 3'd4,
      SEL_IEN    = 3'd5,
      SEL_EDGE   = 3'd6,
      SEL_FLAG   = 3'd7
   } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
   parameter int NPINS = 8
) (
   input  logic [NPINS-1:0] drive_q,
   input  logic [NPINS-1:0] dir_q,
   input  logic [NPINS-1:0] res_q,
   input  logic [NPINS-1:0] func_q,
   input  logic [NPINS-1:0] periph_out,
   input  logic [NPINS-1:0] periph_oe,
   input  logic [NPINS-1:0] analog_dis,
   input  logic [NPINS-1:0] lvl_sync,
   output logic [NPINS-1:0] pad_oe,
   output logic [NPINS-1:0] pad_dout,
   output logic [NPINS-1:0] pad_pull_en,
   output logic [NPINS-1:0] lvl_masked,
   output logic [NPINS-1:0] io_mode
);
   generate
      for (genvar i = 0; i < NPINS; i++) begin : g_pin
         logic drv_req;
         logic drv_val;
         always_comb begin
            drv_req = func_q[i] ? periph_oe[i]  : dir_q[i];
            drv_val = func_q[i] ? periph_out[i] : drive_q[i];
         end
         assign pad_oe[i]      = drv_req & ~analog_dis[i];
         assign pad_dout[i]    = drv_req ? drv_val : drive_q[i];
         assign pad_pull_en[i] = res_q[i] & ~drv_req & ~analog_dis[i];
         assign lvl_masked[i]  = lvl_sync[i] & ~analog_dis[i];
         assign io_mode[i]     = ~func_q[i] & ~analog_dis[i];
      end
   endgenerate
endmodule

// File: rtl/gpio_edge_flag.sv
module gpio_edge_flag #(
   parameter int NPINS = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] lvl,
   input  logic [NPINS-1:0] io_mode,
   input  logic [NPINS-1:0] edge_q,
   input  logic             flag_we,
   input  logic [NPINS-1:0] flag_wdata,
   output logic [NPINS-1:0] flag_q
);
   logic [NPINS-1:0] prev_q;
   logic [NPINS-1:0] hit;
   logic [NPINS-1:0] flag_d;

   always_comb begin
      hit    = io_mode & ((~edge_q & lvl & ~prev_q) | (edge_q & ~lvl & prev_q));
      flag_d = (flag_we ? flag_wdata : flag_q) | hit;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         prev_q <= '0;
         flag_q <= '0;
      end else begin
         prev_q <= lvl;
         flag_q <= flag_d;
      end
endmodule

// File: rtl/gpio_port_mux.sv
module gpio_port_mux
   import gpio_pkg::*;
#(
   parameter int NPINS       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REG_AW-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [NPINS-1:0]    bus_wdata,
   output logic [NPINS-1:0]    bus_rdata,
   input  logic [NPINS-1:0]    pad_in,
   output logic [NPINS-1:0]    pad_oe,
   output logic [NPINS-1:0]    pad_dout,
   output logic [NPINS-1:0]    pad_pull_en,
   input  logic [NPINS-1:0]    periph_out,
   input  logic [NPINS-1:0]    periph_oe,
   output logic [NPINS-1:0]    periph_in,
   input  logic [NPINS-1:0]    analog_dis,
   output logic [NPINS-1:0]    pin_irq,
   output logic                port_irq
);
   generate
      if (NPINS < 1) begin : g_bad_width
         $error("gpio_port_mux: NPINS must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("gpio_port_mux: SYNC_STAGES must be at least 2");
      end
   endgenerate

   reg_sel_e         sel;
   logic [NPINS-1:0] drive_q, dir_q, res_q, func_q, ien_q, edge_q;
   logic [NPINS-1:0] flag_q;
   logic [NPINS-1:0] lvl_sync, lvl_masked, io_mode;
   logic             flag_we;

   assign sel     = reg_sel_e'(bus_addr);
   assign flag_we = bus_we && (sel == SEL_FLAG);

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         drive_q <= '0;
         dir_q   <= '0;
         res_q   <= '0;
         func_q  <= '0;
         ien_q   <= '0;
         edge_q  <= '0;
      end else if (bus_we) begin
         case (sel)
            SEL_DRIVE: drive_q <= bus_wdata;
            SEL_DIR:   dir_q   <= bus_wdata;
            SEL_RES:   res_q   <= bus_wdata;
            SEL_FUNC:  func_q  <= bus_wdata;
            SEL_IEN:   ien_q   <= bus_wdata;
            SEL_EDGE:  edge_q  <= bus_wdata;
            default:   ;
         endcase
      end

   always_comb begin
      case (sel)
         SEL_LEVEL: bus_rdata = lvl_masked;
         SEL_DRIVE: bus_rdata = drive_q;
         SEL_DIR:   bus_rdata = dir_q;
         SEL_RES:   bus_rdata = res_q;
         SEL_FUNC:  bus_rdata = func_q;
         SEL_IEN:   bus_rdata = ien_q;
         SEL_EDGE:  bus_rdata = edge_q;
         default:   bus_rdata = flag_q;
      endcase
   end

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (pad_in), .q (lvl_sync)
   );

   gpio_pin_mux #(.NPINS(NPINS)) u_mux (
      .drive_q     (drive_q),
      .dir_q       (dir_q),
      .res_q       (res_q),
      .func_q      (func_q),
      .periph_out  (periph_out),
      .periph_oe   (periph_oe),
      .analog_dis  (analog_dis),
      .lvl_sync    (lvl_sync),
      .pad_oe      (pad_oe),
      .pad_dout    (pad_dout),
      .pad_pull_en (pad_pull_en),
      .lvl_masked  (lvl_masked),
      .io_mode     (io_mode)
   );

   gpio_edge_flag #(.NPINS(NPINS)) u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl        (lvl_sync),
      .io_mode    (io_mode),
      .edge_q     (edge_q),
      .flag_we    (flag_we),
      .flag_wdata (bus_wdata),
      .flag_q     (flag_q)
   );

   assign periph_in = lvl_masked;
   assign pin_irq   = flag_q & ien_q;
   assign port_irq  = |pin_irq;
endmodule

// File: rtl/gpio_port_mux_chk.sv
module gpio_port_mux_chk #(
   parameter int NPINS = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flag_we,
   input logic [NPINS-1:0] flag_q,
   input logic [NPINS-1:0] func_q,
   input logic [NPINS-1:0] ien_q,
   input logic [NPINS-1:0] analog_dis,
   input logic [NPINS-1:0] pad_oe,
   input logic [NPINS-1:0] pad_pull_en,
   input logic [NPINS-1:0] periph_in,
   input logic [NPINS-1:0] pin_irq
);
   p_adis_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe | pad_pull_en | periph_in) & analog_dis) == '0);

   p_pull_not_driven_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pad_pull_en & pad_oe) == '0);

   p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_irq & ~ien_q) == '0);

   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(flag_we) |-> ($past(flag_q) & ~flag_q) == '0);

   p_no_flag_periph_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(flag_we) |-> (flag_q & ~$past(flag_q) & $past(func_q)) == '0);

   p_no_flag_analog_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(flag_we) |-> (flag_q & ~$past(flag_q) & $past(analog_dis)) == '0);
endmodule

bind gpio_port_mux gpio_port_mux_chk #(.NPINS(NPINS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .flag_we     (flag_we),
   .flag_q      (flag_q),
   .func_q      (func_q),
   .ien_q       (ien_q),
   .analog_dis  (analog_dis),
   .pad_oe      (pad_oe),
   .pad_pull_en (pad_pull_en),
   .periph_in   (periph_in),
   .pin_irq     (pin_irq)
);

// File: tb/gpio_port_mux_test.sv
module gpio_port_mux_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [7:0] pad_in = '0;
   logic [7:0] pad_oe, pad_dout, pad_pull_en, periph_in, pin_irq;
   logic [7:0] periph_out = '0, periph_oe = '0, analog_dis = '0;
   logic       port_irq;

   int checks = 0;
   int failures = 0;

   localparam logic [2:0] A_LVL = 3'd0, A_DRV = 3'd1, A_DIR = 3'd2, A_RES = 3'd3,
                          A_FUN = 3'd4, A_IEN = 3'd5, A_EDG = 3'd6, A_FLG = 3'd7;

   always #2.5 clk = ~clk;

   gpio_port_mux uut (
      .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_we (bus_we),
      .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pad_in (pad_in),
      .pad_oe (pad_oe), .pad_dout (pad_dout), .pad_pull_en (pad_pull_en),
      .periph_out (periph_out), .periph_oe (periph_oe), .periph_in (periph_in),
      .analog_dis (analog_dis), .pin_irq (pin_irq), .port_irq (port_irq)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic set_pins(input logic [7:0] v, input int edges);
      @(negedge clk);
      pad_in = v;
      for (int k = 0; k < edges; k++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         check("R1 register after reset", v, 8'h00);
      end
      check("R1 pad_oe after reset", pad_oe, 8'h00);
      check("R1 pull after reset", pad_pull_en, 8'h00);
      check("R1 port_irq after reset", {7'd0, port_irq}, 8'h00);
   endtask

   task automatic t_dir();
      wr(A_DRV, 8'hA5);
      wr(A_DIR, 8'h0F);
      check("R2 pad_oe from direction", pad_oe, 8'h0F);
      check("R2 pad_dout from output reg", pad_dout, 8'hA5);
   endtask

   task automatic t_func();
      @(negedge clk);
      periph_oe = 8'h30; periph_out = 8'hFF;
      wr(A_FUN, 8'hF0);
      check("R3 pad_oe with function select", pad_oe, 8'h3F);
      check("R3 pad_dout with function select", pad_dout, 8'hB5);
      wr(A_FUN, 8'h00);
      wr(A_DIR, 8'h00);
      periph_oe = 8'h00; periph_out = 8'h00;
   endtask

   task automatic t_pull();
      wr(A_RES, 8'hFF);
      wr(A_DRV, 8'h0F);
      wr(A_DIR, 8'h03);
      check("R4 pull on undriven pins", pad_pull_en, 8'hFC);
      check("R4 pull direction from output reg", pad_dout, 8'h0F);
      wr(A_RES, 8'h00);
      wr(A_DIR, 8'h00);
   endtask

   task automatic t_level();
      logic [7:0] v;
      set_pins(8'h5A, 1);
      rd(A_LVL, v);
      check("R5 level not yet after one edge", v, 8'h00);
      @(negedge clk);
      rd(A_LVL, v);
      check("R5 level after two edges", v, 8'h5A);
      check("R5 periph_in level", periph_in, 8'h5A);
      wr(A_LVL, 8'hFF);
      rd(A_LVL, v);
      check("R5 write to level ignored", v, 8'h5A);
      wr(A_FLG, 8'h00);
   endtask

   task automatic t_edges();
      logic [7:0] v;
      set_pins(8'h5B, 3);
      rd(A_FLG, v);
      check("R6 rising edge flags pin0", v, 8'h01);
      set_pins(8'h59, 3);
      rd(A_FLG, v);
      check("R6 falling edge ignored with select 0", v, 8'h01);
      wr(A_EDG, 8'h02);
      set_pins(8'h5B, 3);
      rd(A_FLG, v);
      check("R6 rising edge ignored with select 1", v, 8'h01);
      set_pins(8'h59, 3);
      rd(A_FLG, v);
      check("R6 falling edge flags with select 1", v, 8'h03);
   endtask

   task automatic t_irq();
      wr(A_IEN, 8'h01);
      check("R7 pin_irq needs flag and enable", pin_irq, 8'h01);
      check("R7 port_irq is OR", {7'd0, port_irq}, 8'h01);
      wr(A_IEN, 8'h00);
      check("R7 no irq when disabled", {pin_irq[7:1], port_irq}, 8'h00);
   endtask

   task automatic t_soft();
      logic [7:0] v;
      wr(A_FLG, 8'h00);
      rd(A_FLG, v);
      check("R10 software clear", v, 8'h00);
      wr(A_IEN, 8'h80);
      wr(A_FLG, 8'h80);
      check("R10 software set raises irq", pin_irq, 8'h80);
      check("R10 port_irq from software flag", {7'd0, port_irq}, 8'h01);
      wr(A_FLG, 8'h00);
      wr(A_IEN, 8'h00);
      wr(A_EDG, 8'h00);
   endtask

   task automatic t_select_change();
      logic [7:0] v;
      // pins 0, 3, 4, 6 are high here
      wr(A_EDG, 8'h59);
      wr(A_EDG, 8'h00);
      repeat (2) @(negedge clk);
      rd(A_FLG, v);
      check("R12 edge-select change sets no flag", v, 8'h00);
   endtask

   task automatic t_func_edge();
      logic [7:0] v;
      wr(A_FUN, 8'h20);
      set_pins(8'h79, 3);
      rd(A_FLG, v);
      check("R9 no flag on peripheral pin", v, 8'h00);
      wr(A_FUN, 8'h00);
      @(negedge clk);
      rd(A_FLG, v);
      check("R9 no flag after returning to I/O", v, 8'h00);
   endtask

   task automatic t_analog();
      logic [7:0] v;
      @(negedge clk);
      analog_dis = 8'h80;
      wr(A_DIR, 8'h80);
      check("R8 driver off under analog disable", pad_oe, 8'h00);
      wr(A_DIR, 8'h00);
      wr(A_RES, 8'h80);
      check("R8 pull off under analog disable", pad_pull_en, 8'h00);
      wr(A_RES, 8'h00);
      set_pins(8'hF9, 3);
      rd(A_LVL, v);
      check("R8 level bit reads 0", v, 8'h79);
      check("R8 periph_in bit 0", periph_in, 8'h79);
      rd(A_FLG, v);
      check("R8 no edge flag", v, 8'h00);
      @(negedge clk);
      analog_dis = 8'h00;
      repeat (2) @(negedge clk);
      rd(A_LVL, v);
      check("R8 level visible after release", v, 8'hF9);
      rd(A_FLG, v);
      check("R8 no flag on release", v, 8'h00);
   endtask

   task automatic t_race();
      logic [7:0] v;
      wr(A_FLG, 8'h04);
      @(negedge clk);
      pad_in = 8'hFD;
      repeat (2) @(negedge clk);
      bus_addr = A_FLG; bus_wdata = 8'h00; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
      rd(A_FLG, v);
      check("R11 edge beats software clear", v, 8'h04);
      wr(A_FLG, 8'h00);
      rd(A_FLG, v);
      check("R10 plain clear afterwards", v, 8'h00);
   endtask

   initial begin
      #200000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_dir();
      t_func();
      t_pull();
      t_level();
      t_edges();
      t_irq();
      t_soft();
      t_select_change();
      t_func_edge();
      t_analog();
      t_race();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule